// File: doc/BRIEF.md
# Segment Protection Fault Classifier

This block sits beside an instruction execution pipeline. For every memory-operand reference or privileged instruction attempt, it decides whether the operation may go ahead. If it may not, it picks the exception vector to raise. The caller presents one request per cycle: the operating mode, the segment involved, the operand offset and length, the segment limit and descriptor status bits, the privilege levels, an instruction class, and the system-management gate inputs. One cycle later the block returns a registered verdict: a fault flag and an 8-bit vector. It also returns permission bits for flag-register writes and a clear-zero-flag indication for selector-verification instructions.

The vector depends on which segment is involved. The stack segment reports both its limit faults and its not-present faults as vector 12. The other segments report limit faults as vector 13 and not-present faults as vector 11. When several causes apply to one request, a fixed priority order picks a single vector. The verdict stays on the outputs until the next request is accepted.

Top module: `seg_fault_classifier`

## Requirements
- R1: After reset, every output is 0. A request sampled with `req_valid` high produces `res_valid` high for exactly the following cycle. `fault_valid`, `fault_vector`, `clear_zf` and the three write enables take their new values in that same cycle and hold them until the next accepted request.
- R2: The operand end offset is `op_offset + op_len_m1`, computed without wrap-around. In real mode (`prot_mode`=0), a memory reference (`mem_ref`=1) whose end offset exceeds 0xFFFF faults. The vector is 12 when `seg_idx`=2 (stack) and 13 for any other segment code. In real mode `seg_limit` is ignored.
- R3: In real mode, the protected-only class (`op_class`=2) and the selector-verify class (`op_class`=6) raise vector 6.
- R4: In protected mode, a memory reference whose end offset exceeds `seg_limit` raises vector 12 on the stack segment and vector 13 on any other segment. A memory reference with `seg_rights_ok`=0 raises vector 13 on any segment, and this takes precedence over a limit fault in the same request.
- R5: In protected mode, a segment load (`op_class`=1) with `seg_present`=0 raises vector 12 for the stack segment and vector 11 for any other segment. In real mode, a segment load never faults on presence or privilege.
- R6: In protected mode, a segment load raises vector 13 when its privilege check fails.
  - For the stack segment, the check requires CPL = RPL = DPL.
  - For any other segment, it requires DPL ≥ max(CPL, RPL).
- R7: In protected mode, a most-privileged-only instruction (`op_class`=3) raises vector 13 when CPL > 0.
- R8: In protected mode, an I/O-sensitive instruction (`op_class`=4) raises vector 13 when CPL > IOPL.
- R9: A system-management instruction (`op_class`=5) raises vector 6 unless all of the following hold:
  - `smm_enable`=1;
  - `smm_size` is nonzero;
  - the effective CPL is 0, where real mode counts as CPL 0;
  - `smm_access_en`=1 or `in_smm_handler`=1.
- R10: A protected-mode selector-verify instruction (`op_class`=6) never faults on privilege or presence. Instead, `clear_zf` is 1 when `seg_present`=0 or when DPL < max(CPL, RPL). `clear_zf` is 0 whenever the request faults.
- R11: For a flags-restore instruction (`op_class`=7) that does not fault, the write enables are set as follows. All other requests leave the three enables at 0.
  - In real mode, `wr_if_en`, `wr_iopl_en` and `wr_vm_en` are all 1.
  - In protected mode, `wr_if_en` = (CPL ≤ IOPL), and `wr_iopl_en` = `wr_vm_en` = (CPL = 0).
- R12: When several causes coincide, the vector follows this priority: invalid opcode (6) first, then privilege (13), then not-present (11/12), then rights/limit (13/12).
- R13: `fault_valid` is 1 exactly when `fault_vector` is nonzero, and the vector is always one of 0, 6, 11, 12 or 13. Class codes 0 and 8 to 15 carry only the memory-operand checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; inputs are sampled when high |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| seg_idx | input | 3 | Segment code; 2 = stack segment |
| op_class | input | 4 | Instruction class code (see requirements) |
| mem_ref | input | 1 | Request carries a memory operand |
| op_offset | input | OFFW | Operand start offset |
| op_len_m1 | input | LENW | Operand length in bytes minus one |
| seg_limit | input | OFFW | Segment limit (protected mode) |
| seg_present | input | 1 | Descriptor present bit |
| seg_rights_ok | input | 1 | Access rights permit the reference |
| cpl | input | 2 | Current privilege level |
| rpl | input | 2 | Requested privilege level of the selector |
| dpl | input | 2 | Descriptor privilege level |
| iopl | input | 2 | I/O privilege level |
| smm_enable | input | 1 | System-management interrupt enabled |
| smm_size | input | SMW | System-management region size |
| smm_access_en | input | 1 | System-management access enable |
| in_smm_handler | input | 1 | Currently inside the system-management handler |
| res_valid | output | 1 | Verdict updated this cycle |
| fault_valid | output | 1 | Held: last request faulted |
| fault_vector | output | 8 | Held: exception vector, 0 when no fault |
| clear_zf | output | 1 | Held: selector-verify result clears zero flag |
| wr_if_en | output | 1 | Held: interrupt-enable flag write permitted |
| wr_iopl_en | output | 1 | Held: IOPL field write permitted |
| wr_vm_en | output | 1 | Held: VM flag write permitted |

## Verification
The assertions assume that the inputs are stable and defined whenever `req_valid` is high at a clock edge. They also assume that `op_class` and `seg_idx` may take any value, including unused codes. They assume nothing about how the privilege fields relate to one another.

The stimulus changes inputs only on the falling clock edge. It mixes directed corner cases with several hundred random requests that cover every class code, all eight segment codes and both modes. Idle gaps are placed between requests so that the hold behaviour is observed under all of these conditions.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [3:0] {
        OC_PLAIN   = 4'd0,
        OC_SEGLOAD = 4'd1,
        OC_PMONLY  = 4'd2,
        OC_RING0   = 4'd3,
        OC_IOSENS  = 4'd4,
        OC_SMM     = 4'd5,
        OC_VERIFY  = 4'd6,
        OC_FLAGRST = 4'd7
    } op_class_e;

    localparam logic [2:0] SEG_STACK = 3'd2;

    localparam logic [7:0] VEC_NONE   = 8'd0;
    localparam logic [7:0] VEC_UD     = 8'd6;
    localparam logic [7:0] VEC_NP     = 8'd11;
    localparam logic [7:0] VEC_STACK  = 8'd12;
    localparam logic [7:0] VEC_GP     = 8'd13;

    typedef struct packed {
        logic ud;
        logic priv;
        logic np;
        logic rights;
        logic limit;
    } cause_t;

    typedef struct packed {
        logic       fault;
        logic [7:0] vec;
        logic       zf_clr;
        logic       wr_if;
        logic       wr_iopl;
        logic       wr_vm;
    } verdict_t;

    function automatic logic [1:0] max2(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic load_priv_ok(input logic stk, input logic [1:0] c,
                                          input logic [1:0] r, input logic [1:0] d);
        if (stk) return (c == r) && (c == d);
        return d >= max2(c, r);
    endfunction

endpackage

// File: rtl/sfc_limit_chk.sv
module sfc_limit_chk
    import sfc_pkg::*;
#(
    parameter int OFFW = 32,
    parameter int LENW = 3
) (
    input  logic            prot,
    input  logic            mem_ref,
    input  logic [OFFW-1:0] offset,
    input  logic [LENW-1:0] len_m1,
    input  logic [OFFW-1:0] limit,
    input  logic            rights_ok,
    output logic            limit_viol,
    output logic            rights_viol
);
    localparam int EW = OFFW + 1;
    localparam logic [EW-1:0] REAL_CAP = EW'(17'h0FFFF);

    logic [EW-1:0] end_off;
    logic [EW-1:0] eff_limit;

    always_comb begin
        end_off   = {1'b0, offset} + EW'(len_m1);
        eff_limit = prot ? {1'b0, limit} : REAL_CAP;
        limit_viol  = mem_ref && (end_off > eff_limit);
        rights_viol = mem_ref && prot && !rights_ok;
    end

    // R2: a real-mode reference that stays inside the fixed cap never trips the limit
    always_comb begin
        if (mem_ref && !prot && ({1'b0, offset} + EW'(len_m1)) <= REAL_CAP)
            assert_real_cap_R2: assert (!limit_viol);
    end

endmodule

// File: rtl/sfc_rules.sv
module sfc_rules
    import sfc_pkg::*;
#(
    parameter int SMW = 24
) (
    input  logic           prot,
    input  op_class_e      cls,
    input  logic           is_stack,
    input  logic           present,
    input  logic [1:0]     cpl,
    input  logic [1:0]     rpl,
    input  logic [1:0]     dpl,
    input  logic [1:0]     iopl,
    input  logic           smm_en,
    input  logic [SMW-1:0] smm_size,
    input  logic           smm_acc,
    input  logic           smm_hdl,
    output logic           ud,
    output logic           priv,
    output logic           np,
    output logic           zf_clr,
    output logic           wr_if,
    output logic           wr_iopl,
    output logic           wr_vm
);
    logic [1:0] cpl_eff;
    logic       smm_gate;

    always_comb begin
        cpl_eff  = prot ? cpl : 2'd0;
        smm_gate = smm_en && (|smm_size) && (cpl_eff == 2'd0) && (smm_acc || smm_hdl);
        ud = 1'b0; priv = 1'b0; np = 1'b0; zf_clr = 1'b0;
        wr_if = 1'b0; wr_iopl = 1'b0; wr_vm = 1'b0;
        unique case (cls)
            OC_SEGLOAD: begin
                priv = prot && !load_priv_ok(is_stack, cpl, rpl, dpl);
                np   = prot && !present;
            end
            OC_PMONLY:  ud   = !prot;
            OC_RING0:   priv = prot && (cpl != 2'd0);
            OC_IOSENS:  priv = prot && (cpl > iopl);
            OC_SMM:     ud   = !smm_gate;
            OC_VERIFY: begin
                ud     = !prot;
                zf_clr = prot && (!present || !load_priv_ok(1'b0, cpl, rpl, dpl));
            end
            OC_FLAGRST: begin
                wr_if   = !prot || (cpl <= iopl);
                wr_iopl = cpl_eff == 2'd0;
                wr_vm   = cpl_eff == 2'd0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sfc_arbiter.sv
module sfc_arbiter
    import sfc_pkg::*;
(
    input  cause_t   cause,
    input  logic     is_stack,
    input  logic     zf_clr,
    input  logic     wr_if,
    input  logic     wr_iopl,
    input  logic     wr_vm,
    output verdict_t verdict
);
    always_comb begin
        verdict = '0;
        if (cause.ud)          verdict.vec = VEC_UD;
        else if (cause.priv)   verdict.vec = VEC_GP;
        else if (cause.np)     verdict.vec = is_stack ? VEC_STACK : VEC_NP;
        else if (cause.rights) verdict.vec = VEC_GP;
        else if (cause.limit)  verdict.vec = is_stack ? VEC_STACK : VEC_GP;
        verdict.fault = |cause;
        if (!verdict.fault) begin
            verdict.zf_clr  = zf_clr;
            verdict.wr_if   = wr_if;
            verdict.wr_iopl = wr_iopl;
            verdict.wr_vm   = wr_vm;
        end
    end

endmodule

// File: rtl/seg_fault_classifier.sv
module seg_fault_classifier
    import sfc_pkg::*;
#(
    parameter int OFFW = 32,
    parameter int LENW = 3,
    parameter int SMW  = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            prot_mode,
    input  logic [2:0]      seg_idx,
    input  logic [3:0]      op_class,
    input  logic            mem_ref,
    input  logic [OFFW-1:0] op_offset,
    input  logic [LENW-1:0] op_len_m1,
    input  logic [OFFW-1:0] seg_limit,
    input  logic            seg_present,
    input  logic            seg_rights_ok,
    input  logic [1:0]      cpl,
    input  logic [1:0]      rpl,
    input  logic [1:0]      dpl,
    input  logic [1:0]      iopl,
    input  logic            smm_enable,
    input  logic [SMW-1:0]  smm_size,
    input  logic            smm_access_en,
    input  logic            in_smm_handler,
    output logic            res_valid,
    output logic            fault_valid,
    output logic [7:0]      fault_vector,
    output logic            clear_zf,
    output logic            wr_if_en,
    output logic            wr_iopl_en,
    output logic            wr_vm_en
);
    logic      is_stack;
    op_class_e cls;
    cause_t    cause;
    logic      zf_c, wif_c, wiopl_c, wvm_c;
    verdict_t  verdict_d, verdict_q;
    logic      rv_q;

    assign is_stack = (seg_idx == SEG_STACK);
    assign cls      = op_class_e'(op_class);

    sfc_limit_chk #(.OFFW(OFFW), .LENW(LENW)) u_lim (
        .prot(prot_mode), .mem_ref(mem_ref), .offset(op_offset), .len_m1(op_len_m1),
        .limit(seg_limit), .rights_ok(seg_rights_ok),
        .limit_viol(cause.limit), .rights_viol(cause.rights)
    );

    sfc_rules #(.SMW(SMW)) u_rules (
        .prot(prot_mode), .cls(cls), .is_stack(is_stack), .present(seg_present),
        .cpl(cpl), .rpl(rpl), .dpl(dpl), .iopl(iopl),
        .smm_en(smm_enable), .smm_size(smm_size), .smm_acc(smm_access_en),
        .smm_hdl(in_smm_handler),
        .ud(cause.ud), .priv(cause.priv), .np(cause.np),
        .zf_clr(zf_c), .wr_if(wif_c), .wr_iopl(wiopl_c), .wr_vm(wvm_c)
    );

    sfc_arbiter u_arb (
        .cause(cause), .is_stack(is_stack), .zf_clr(zf_c),
        .wr_if(wif_c), .wr_iopl(wiopl_c), .wr_vm(wvm_c), .verdict(verdict_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
            rv_q      <= 1'b0;
        end else begin
            rv_q <= req_valid;
            if (req_valid) verdict_q <= verdict_d;
        end
    end

    assign res_valid    = rv_q;
    assign fault_valid  = verdict_q.fault;
    assign fault_vector = verdict_q.vec;
    assign clear_zf     = verdict_q.zf_clr;
    assign wr_if_en     = verdict_q.wr_if;
    assign wr_iopl_en   = verdict_q.wr_iopl;
    assign wr_vm_en     = verdict_q.wr_vm;

    assert_result_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(req_valid));

    assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(fault_vector) && $stable(fault_valid) && $stable(clear_zf));

    assert_vector_legal_R13: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (fault_vector == VEC_UD || fault_vector == VEC_NP ||
                         fault_vector == VEC_STACK || fault_vector == VEC_GP));

    assert_no_vector_without_fault_R13: assert property (@(posedge clk) disable iff (rst)
        !fault_valid |-> fault_vector == VEC_NONE);

    assert_zf_only_clean_R10: assert property (@(posedge clk) disable iff (rst)
        clear_zf |-> !fault_valid && !wr_if_en);

    assert_iopl_implies_if_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_iopl_en || wr_vm_en) |-> wr_if_en && !fault_valid);

endmodule

// File: tb/sim_seg_fault_classifier.sv
module sim_seg_fault_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int OFFW = 32;
    localparam int LENW = 3;
    localparam int SMW  = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, prot_mode = 0, mem_ref = 0;
    logic [2:0] seg_idx = 0;
    logic [3:0] op_class = 0;
    logic [OFFW-1:0] op_offset = 0, seg_limit = 0;
    logic [LENW-1:0] op_len_m1 = 0;
    logic seg_present = 0, seg_rights_ok = 0;
    logic [1:0] cpl = 0, rpl = 0, dpl = 0, iopl = 0;
    logic smm_enable = 0, smm_access_en = 0, in_smm_handler = 0;
    logic [SMW-1:0] smm_size = 0;
    logic res_valid, fault_valid, clear_zf, wr_if_en, wr_iopl_en, wr_vm_en;
    logic [7:0] fault_vector;

    int n_cmp = 0;
    int n_bad = 0;
    bit armed = 0;
    bit done = 0;
    string cur_tag = "R1 reset";
    string exp_tag = "R1 reset";
    int e_rv = 0, e_flt = 0, e_vec = 0, e_zf = 0, e_if = 0, e_iopl = 0, e_vm = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_fault_classifier #(.OFFW(OFFW), .LENW(LENW), .SMW(SMW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .prot_mode(prot_mode),
        .seg_idx(seg_idx), .op_class(op_class), .mem_ref(mem_ref),
        .op_offset(op_offset), .op_len_m1(op_len_m1), .seg_limit(seg_limit),
        .seg_present(seg_present), .seg_rights_ok(seg_rights_ok),
        .cpl(cpl), .rpl(rpl), .dpl(dpl), .iopl(iopl),
        .smm_enable(smm_enable), .smm_size(smm_size), .smm_access_en(smm_access_en),
        .in_smm_handler(in_smm_handler),
        .res_valid(res_valid), .fault_valid(fault_valid), .fault_vector(fault_vector),
        .clear_zf(clear_zf), .wr_if_en(wr_if_en), .wr_iopl_en(wr_iopl_en),
        .wr_vm_en(wr_vm_en)
    );

    // Behavioural reference: later rules overwrite earlier ones, so the last
    // applicable rule is the one of highest priority (R12).
    task automatic run_model();
        int c, r, d, io, ceff, cls, mx, vec;
        longint last, cap;
        bit stk, pm;
        c = cpl; r = rpl; d = dpl; io = iopl; cls = op_class;
        pm = prot_mode; stk = (seg_idx == 3'd2);
        ceff = pm ? c : 0;
        mx = (c > r) ? c : r;
        vec = 0;
        if (mem_ref) begin
            last = longint'(op_offset) + longint'(op_len_m1);
            cap  = pm ? longint'(seg_limit) : 64'd65535;
            if (last > cap) vec = stk ? 12 : 13;
            if (pm && !seg_rights_ok) vec = 13;
        end
        if (pm && cls == 1 && !seg_present) vec = stk ? 12 : 11;
        if (pm && cls == 1) begin
            if (stk ? !(c == r && c == d) : (d < mx)) vec = 13;
        end
        if (pm && cls == 3 && c > 0) vec = 13;
        if (pm && cls == 4 && c > io) vec = 13;
        if (!pm && (cls == 2 || cls == 6)) vec = 6;
        if (cls == 5 && !(smm_enable && smm_size != 0 && ceff == 0 &&
                          (smm_access_en || in_smm_handler))) vec = 6;
        e_vec = vec;
        e_flt = (vec != 0);
        e_zf = 0; e_if = 0; e_iopl = 0; e_vm = 0;
        if (vec == 0 && cls == 6 && pm && (!seg_present || d < mx)) e_zf = 1;
        if (vec == 0 && cls == 7) begin
            e_if   = (!pm || c <= io);
            e_iopl = (ceff == 0);
            e_vm   = (ceff == 0);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            e_rv = 0; e_flt = 0; e_vec = 0; e_zf = 0; e_if = 0; e_iopl = 0; e_vm = 0;
            exp_tag = "R1 reset";
            armed = 1;
        end else begin
            e_rv = req_valid;
            if (req_valid) begin
                run_model();
                exp_tag = cur_tag;
            end else begin
                exp_tag = "R1 hold";
            end
        end
    end

    task automatic cmp(input int act, input int exp, input string nm);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", exp_tag, nm, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            cmp(res_valid, e_rv, "res_valid");
            cmp(fault_valid, e_flt, "fault_valid");
            cmp(fault_vector, e_vec, "fault_vector");
            cmp(clear_zf, e_zf, "clear_zf");
            cmp(wr_if_en, e_if, "wr_if_en");
            cmp(wr_iopl_en, e_iopl, "wr_iopl_en");
            cmp(wr_vm_en, e_vm, "wr_vm_en");
        end
    end

    // Called at a falling edge: restores a neutral protected-mode request.
    task automatic base();
        prot_mode = 1; seg_idx = 3'd3; op_class = 4'd0; mem_ref = 0;
        op_offset = 0; op_len_m1 = 0; seg_limit = '1;
        seg_present = 1; seg_rights_ok = 1;
        cpl = 0; rpl = 0; dpl = 0; iopl = 0;
        smm_enable = 0; smm_size = 0; smm_access_en = 0; in_smm_handler = 0;
    endtask

    task automatic go(input string tag);
        cur_tag = tag;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        idle(1);

        // R2 real-mode fixed cap
        base(); prot_mode = 0; mem_ref = 1; seg_limit = 32'h10;
        op_offset = 32'hFFF8; op_len_m1 = 3'd7; go("R2 end at cap");
        base(); prot_mode = 0; mem_ref = 1; op_offset = 32'hFFFE; op_len_m1 = 3'd3; go("R2 cross DS");
        idle(2);
        base(); prot_mode = 0; mem_ref = 1; seg_idx = 3'd2; op_offset = 32'hFFFE; op_len_m1 = 3'd3; go("R2 cross SS");
        base(); prot_mode = 0; mem_ref = 1; seg_idx = 3'd1; op_offset = 32'h10000; go("R2 beyond CS");

        // R3
        base(); prot_mode = 0; op_class = 4'd2; go("R3 pm-only real");
        base(); prot_mode = 0; op_class = 4'd6; go("R3 verify real");
        base(); op_class = 4'd2; go("R3 pm-only prot");

        // R4
        base(); mem_ref = 1; seg_limit = 32'h1000; op_offset = 32'hFFF; go("R4 at limit");
        base(); mem_ref = 1; seg_limit = 32'h1000; op_offset = 32'hFFF; op_len_m1 = 3'd1; go("R4 cross DS");
        base(); mem_ref = 1; seg_idx = 3'd2; seg_limit = 32'h1000; op_offset = 32'hFFF; op_len_m1 = 3'd1; go("R4 cross SS");
        base(); mem_ref = 1; seg_rights_ok = 0; go("R4 rights DS");
        base(); mem_ref = 1; seg_idx = 3'd2; seg_rights_ok = 0; seg_limit = 0; op_len_m1 = 3'd4; go("R4 rights over limit SS");
        base(); mem_ref = 1; op_offset = '1; op_len_m1 = 3'd1; go("R4 wrap top");

        // R5
        base(); op_class = 4'd1; seg_present = 0; go("R5 np DS");
        base(); op_class = 4'd1; seg_idx = 3'd2; seg_present = 0; go("R5 np SS");
        base(); prot_mode = 0; op_class = 4'd1; seg_present = 0; cpl = 3; go("R5 real load");

        // R6
        base(); op_class = 4'd1; cpl = 3; rpl = 0; dpl = 2; go("R6 DS cpl high");
        base(); op_class = 4'd1; cpl = 1; rpl = 2; dpl = 2; go("R6 DS ok");
        base(); op_class = 4'd1; cpl = 0; rpl = 3; dpl = 2; go("R6 DS rpl high");
        base(); op_class = 4'd1; seg_idx = 3'd2; cpl = 1; rpl = 1; dpl = 1; go("R6 SS ok");
        base(); op_class = 4'd1; seg_idx = 3'd2; cpl = 1; rpl = 1; dpl = 2; go("R6 SS mismatch");

        // R7, R8
        base(); op_class = 4'd3; cpl = 1; go("R7 ring1");
        base(); op_class = 4'd3; go("R7 ring0");
        base(); prot_mode = 0; op_class = 4'd3; cpl = 3; go("R7 real");
        base(); op_class = 4'd4; cpl = 3; iopl = 2; go("R8 over iopl");
        base(); op_class = 4'd4; cpl = 2; iopl = 2; go("R8 equal iopl");

        // R9
        base(); op_class = 4'd5; smm_enable = 1; smm_size = 24'h100; smm_access_en = 1; go("R9 gate open");
        base(); op_class = 4'd5; smm_enable = 1; smm_size = 24'h100; in_smm_handler = 1; go("R9 in handler");
        base(); op_class = 4'd5; smm_enable = 1; smm_size = 0; smm_access_en = 1; go("R9 zero size");
        base(); op_class = 4'd5; smm_enable = 0; smm_size = 24'h1; smm_access_en = 1; go("R9 disabled");
        base(); op_class = 4'd5; smm_enable = 1; smm_size = 24'h1; smm_access_en = 1; cpl = 1; go("R9 cpl1");
        base(); op_class = 4'd5; smm_enable = 1; smm_size = 24'h1; go("R9 no access");
        base(); prot_mode = 0; op_class = 4'd5; smm_enable = 1; smm_size = 24'h1; smm_access_en = 1; cpl = 3; go("R9 real cpl ignored");

        // R10
        base(); op_class = 4'd6; cpl = 3; dpl = 1; go("R10 priv clear");
        base(); op_class = 4'd6; seg_present = 0; dpl = 3; go("R10 np clear");
        base(); op_class = 4'd6; cpl = 1; rpl = 1; dpl = 2; go("R10 ok");
        base(); op_class = 4'd6; cpl = 3; mem_ref = 1; seg_rights_ok = 0; go("R10 fault masks zf");

        // R11
        base(); op_class = 4'd7; go("R11 cpl0");
        base(); op_class = 4'd7; cpl = 2; iopl = 3; go("R11 cpl le iopl");
        base(); op_class = 4'd7; cpl = 3; iopl = 1; go("R11 cpl gt iopl");
        base(); prot_mode = 0; op_class = 4'd7; cpl = 3; go("R11 real");
        base(); op_class = 4'd7; mem_ref = 1; seg_idx = 3'd2; seg_limit = 0; op_len_m1 = 3'd1; go("R11 fault masks");

        // R12
        base(); op_class = 4'd1; seg_present = 0; cpl = 3; dpl = 0; mem_ref = 1; seg_rights_ok = 0; go("R12 priv over np");
        base(); op_class = 4'd1; seg_idx = 3'd2; seg_present = 0; mem_ref = 1; seg_rights_ok = 0; go("R12 np over rights");
        base(); op_class = 4'd5; cpl = 3; mem_ref = 1; seg_limit = 0; op_len_m1 = 3'd2; go("R12 ud over limit");
        base(); op_class = 4'd1; seg_present = 0; mem_ref = 1; seg_limit = 0; op_len_m1 = 3'd2; go("R12 np over limit");

        // R13 unused class codes
        base(); op_class = 4'd12; cpl = 3; seg_present = 0; go("R13 unused class");
        base(); op_class = 4'd9; mem_ref = 1; seg_idx = 3'd7; seg_limit = 3; op_offset = 3; op_len_m1 = 3'd1; go("R13 unused seg");
        idle(3);

        // R12 R13 random mix
        for (int k = 0; k < 400; k++) begin
            prot_mode = 1'($urandom_range(0, 1));
            seg_idx = 3'($urandom_range(0, 7));
            op_class = 4'($urandom_range(0, 15));
            mem_ref = 1'($urandom_range(0, 1));
            op_offset = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(32'hFFF0, 32'h1000F)) : 32'($urandom);
            op_len_m1 = 3'($urandom_range(0, 7));
            seg_limit = ($urandom_range(0, 1) == 0) ? 32'($urandom_range(32'hFFF0, 32'h1000F)) : 32'($urandom);
            seg_present = 1'($urandom_range(0, 3) != 0);
            seg_rights_ok = 1'($urandom_range(0, 3) != 0);
            cpl = 2'($urandom_range(0, 3)); rpl = 2'($urandom_range(0, 3));
            dpl = 2'($urandom_range(0, 3)); iopl = 2'($urandom_range(0, 3));
            smm_enable = 1'($urandom_range(0, 1));
            smm_size = ($urandom_range(0, 2) == 0) ? '0 : SMW'($urandom);
            smm_access_en = 1'($urandom_range(0, 1));
            in_smm_handler = 1'($urandom_range(0, 1));
            go("R12 random");
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule